// File: doc/BRIEF.md
# Video Memory Table Membership Checker

This block answers one question for every video memory access: which of the display tables could the accessed address belong to? A display controller keeps five tables in a 17-bit video memory: the character name table, the pattern generator table, the colour table, the sprite attribute table and the sprite pattern table. Each table is located by a base field and addressed by an index whose width depends on the display mode. The address an index produces is the index with ones above its top bit, ANDed with a mask. The mask is the base field placed at the top of the address with ones below it. When base bits overlap index bits, a table's footprint has holes. This checker reports membership exactly, holes included.

For each table the block turns the base field and the current mode's index width into two constants, a select mask and a reference value, and registers them. An address hits a table when the address ANDed with the select mask equals the reference. Nothing else is needed, so the test costs one AND and one compare per table. The caller presents an address with a strobe, and one cycle later it receives a valid flag and a five-bit hit vector. Subsystems that cache table contents use this vector to learn that a write touched their table.

Top module: `vtm_table_hit`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `hit_valid_o` is 0 and `hit_o` is all zeros.
- R2: `hit_valid_o` equals `addr_valid_i` delayed by one clock. `hit_o` carries the result for the address sampled with the strobe, and is all zeros in any cycle that follows a clock edge with no strobe. Bit order of `hit_o`: bit 0 name, bit 1 pattern, bit 2 colour, bit 3 sprite attribute, bit 4 sprite pattern.
- R3: A table's mask is its base field placed in address bits 16 down to the table's low bit, with ones below. The low bits are: name 10, pattern 11, colour 6, sprite attribute 7, sprite pattern 11. For a used table, both the mask itself (the highest reachable address) and the mask with its low index-width bits cleared (the lowest reachable address) hit.
- R4: An address hits a used table with index width w exactly when its bits at positions w and above equal the mask's bits there, and none of its bits below w is 1 where the mask is 0. When base and index bits overlap, this makes the footprint non-contiguous.
- R5: Name table index width by mode code: 0 and 1 (text) give 12; 2 (multicolour) and 3 to 5 (tile graphics) give 10; 6 and 7 (packed bitmaps) give 15; 8 and 9 (interleaved bitmaps) give 16.
- R6: Pattern table index width is 11 for mode codes 0 to 3 and 13 for codes 4 and 5. The table is unused for codes 6 to 9.
- R7: Colour table index width is 9 for code 1, 6 for code 3 and 13 for codes 4 and 5. The table is unused for codes 0, 2 and 6 to 9.
- R8: Sprites are off for codes 0 and 1, use the first sprite scheme for codes 2 to 4, and use the second for codes 5 to 9. The sprite attribute width is 7 in the first scheme and 10 in the second. The sprite pattern width is 11 in both.
- R9: A table that is unused in the current mode never hits. Mode codes 10 to 15 are reserved, and no table is used in them.
- R10: A strobe sampled at the same clock edge as a new base field or mode is judged against the old configuration. Any strobe sampled at a later edge is judged against the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Display mode code (see R5 to R9) |
| name_base_i | input | 7 | Name table base field, address bits 16..10 |
| pat_base_i | input | 6 | Pattern table base field, address bits 16..11 |
| col_base_i | input | 11 | Colour table base field, address bits 16..6 |
| spa_base_i | input | 10 | Sprite attribute base field, address bits 16..7 |
| spp_base_i | input | 6 | Sprite pattern base field, address bits 16..11 |
| addr_valid_i | input | 1 | Address strobe |
| addr_i | input | 17 | Address to classify |
| hit_valid_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 5 | Per-table hit vector |

## Verification
The assertions assume that the mode code and base fields change only between clock edges and are otherwise held. Under that assumption, a mode sampled two edges before an output fully determines which tables may report. The bench changes configuration only on falling edges. It holds each configuration for a settling cycle before its sweep, except in the one deliberate R10 case, where it probes in the same cycle as the change. The sweep draws addresses from each table's reachable set, with occasional single-bit corruptions and free addresses, across all sixteen mode codes and several base patterns. Some of those base patterns overlap the index bits.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int N_TBL = 5;
  localparam int T_NAME = 0;
  localparam int T_PAT  = 1;
  localparam int T_COL  = 2;
  localparam int T_SPA  = 3;
  localparam int T_SPP  = 4;

  typedef logic [4:0] width_t;

  typedef enum logic [3:0] {
    M_TXT1 = 4'd0, M_TXT2 = 4'd1, M_MCOL = 4'd2, M_GFX1 = 4'd3,
    M_GFX2 = 4'd4, M_GFX3 = 4'd5, M_GFX4 = 4'd6, M_GFX5 = 4'd7,
    M_GFX6 = 4'd8, M_GFX7 = 4'd9
  } vmode_e;

  // 0: sprites off, 1: first scheme, 2: second scheme
  function automatic logic [1:0] sprite_scheme(logic [3:0] m);
    if (m == M_MCOL || m == M_GFX1 || m == M_GFX2) return 2'd1;
    if (m >= M_GFX3 && m <= M_GFX7)                return 2'd2;
    return 2'd0;
  endfunction

  // Index width of table t in mode m; zero marks an unused table.
  function automatic width_t tbl_width(logic [3:0] m, int t);
    width_t w;
    logic [1:0] ss;
    w  = '0;
    ss = sprite_scheme(m);
    case (t)
      T_NAME: begin
        if (m <= M_TXT2)                      w = 5'd12;
        else if (m <= M_GFX3)                 w = 5'd10;
        else if (m <= M_GFX5)                 w = 5'd15;
        else if (m <= M_GFX7)                 w = 5'd16;
      end
      T_PAT: begin
        if (m <= M_GFX1)                      w = 5'd11;
        else if (m <= M_GFX3)                 w = 5'd13;
      end
      T_COL: begin
        if (m == M_TXT2)                      w = 5'd9;
        else if (m == M_GFX1)                 w = 5'd6;
        else if (m == M_GFX2 || m == M_GFX3)  w = 5'd13;
      end
      T_SPA: begin
        if (ss == 2'd1)                       w = 5'd7;
        else if (ss == 2'd2)                  w = 5'd10;
      end
      T_SPP: begin
        if (ss != 2'd0)                       w = 5'd11;
      end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/vtm_width_decode.sv
module vtm_width_decode
  import vtm_pkg::*;
#(
  parameter int N = N_TBL
) (
  input  logic [3:0]         mode_i,
  output width_t [N-1:0]     width_o
);
  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign width_o[g] = tbl_width(mode_i, g);
  end
endmodule

// File: rtl/vtm_const_gen.sv
module vtm_const_gen
  import vtm_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int N      = N_TBL
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0][ADDR_W-1:0]   mask_i,
  input  width_t [N-1:0]             width_i,
  output logic [N-1:0][ADDR_W-1:0]   sel_o,
  output logic [N-1:0][ADDR_W-1:0]   ref_o,
  output logic [N-1:0]               used_o
);
  localparam logic [ADDR_W-1:0] ALL1 = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] above(width_t w);
    return ALL1 << w;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_tbl
    logic [ADDR_W-1:0] hi_c;
    assign hi_c = above(width_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_o[g]  <= '0;
        ref_o[g]  <= '0;
        used_o[g] <= 1'b0;
      end else begin
        sel_o[g]  <= ~mask_i[g] | hi_c;
        ref_o[g]  <= mask_i[g] & hi_c;
        used_o[g] <= (width_i[g] != '0);
      end
    end
  end
endmodule

// File: rtl/vtm_match.sv
module vtm_match
  import vtm_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int N      = N_TBL
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [N-1:0][ADDR_W-1:0]   sel_i,
  input  logic [N-1:0][ADDR_W-1:0]   ref_i,
  input  logic [N-1:0]               used_i,
  output logic [N-1:0]               hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign hit_o[g] = used_i[g] && ((addr_i & sel_i[g]) == ref_i[g]);
  end
endmodule

// File: rtl/vtm_table_hit.sv
module vtm_table_hit
  import vtm_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int NAME_LSB = 10,
  parameter int PAT_LSB  = 11,
  parameter int COL_LSB  = 6,
  parameter int SPA_LSB  = 7,
  parameter int SPP_LSB  = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 mode_i,
  input  logic [ADDR_W-NAME_LSB-1:0] name_base_i,
  input  logic [ADDR_W-PAT_LSB-1:0]  pat_base_i,
  input  logic [ADDR_W-COL_LSB-1:0]  col_base_i,
  input  logic [ADDR_W-SPA_LSB-1:0]  spa_base_i,
  input  logic [ADDR_W-SPP_LSB-1:0]  spp_base_i,
  input  logic                       addr_valid_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       hit_valid_o,
  output logic [N_TBL-1:0]           hit_o
);
  logic [N_TBL-1:0][ADDR_W-1:0] mask_c;
  width_t [N_TBL-1:0]           width_c;
  logic [N_TBL-1:0][ADDR_W-1:0] sel_q;
  logic [N_TBL-1:0][ADDR_W-1:0] ref_q;
  logic [N_TBL-1:0]             used_q;
  logic [N_TBL-1:0]             hit_c;

  // Base field on top, ones below (R3)
  assign mask_c[T_NAME] = {name_base_i, {NAME_LSB{1'b1}}};
  assign mask_c[T_PAT]  = {pat_base_i,  {PAT_LSB{1'b1}}};
  assign mask_c[T_COL]  = {col_base_i,  {COL_LSB{1'b1}}};
  assign mask_c[T_SPA]  = {spa_base_i,  {SPA_LSB{1'b1}}};
  assign mask_c[T_SPP]  = {spp_base_i,  {SPP_LSB{1'b1}}};

  vtm_width_decode #(.N(N_TBL)) u_wdec (
    .mode_i  (mode_i),
    .width_o (width_c)
  );

  vtm_const_gen #(.ADDR_W(ADDR_W), .N(N_TBL)) u_cgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_i  (mask_c),
    .width_i (width_c),
    .sel_o   (sel_q),
    .ref_o   (ref_q),
    .used_o  (used_q)
  );

  vtm_match #(.ADDR_W(ADDR_W), .N(N_TBL)) u_match (
    .addr_i  (addr_i),
    .sel_i   (sel_q),
    .ref_i   (ref_q),
    .used_i  (used_q),
    .hit_o   (hit_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid_o <= 1'b0;
      hit_o       <= '0;
    end else begin
      hit_valid_o <= addr_valid_i;
      hit_o       <= addr_valid_i ? hit_c : '0;
    end
  end
endmodule

// File: rtl/vtm_table_hit_chk.sv
module vtm_table_hit_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode_i,
  input logic         addr_valid_i,
  input logic         hit_valid_o,
  input logic [N-1:0] hit_o,
  input logic [N-1:0] used_q
);
  // R2: a strobe yields a valid result one cycle later
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_i |=> hit_valid_o);

  // R2: no strobe, no result
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid_i |=> (!hit_valid_o && hit_o == '0));

  // R2: hits only appear alongside the valid flag
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o != '0) |-> hit_valid_o);

  // R9: a table not used by the prior configuration never reports
  p_unused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~$past(used_q)) == '0);

  // R9: reserved mode codes produce no hits
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i, 2) >= 4'd10) |-> (hit_o == '0));

  // R8: text modes carry no sprite tables
  p_text_no_sprite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i, 2) <= 4'd1) |-> (hit_o[4:3] == 2'b00));
endmodule

bind vtm_table_hit vtm_table_hit_chk #(.N(vtm_pkg::N_TBL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .addr_valid_i (addr_valid_i),
  .hit_valid_o  (hit_valid_o),
  .hit_o        (hit_o),
  .used_q       (used_q)
);

// File: tb/vtm_table_hit_bench.sv
`timescale 1ns/1ps
module vtm_table_hit_bench;
  localparam int AW = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic [6:0]  nb;
  logic [5:0]  pb;
  logic [10:0] cb;
  logic [9:0]  ab;
  logic [5:0]  sb;
  logic        av;
  logic [16:0] addr;
  logic        hv;
  logic [4:0]  hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #4 clk = ~clk;

  vtm_table_hit u_vtm_table_hit (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .name_base_i(nb), .pat_base_i(pb), .col_base_i(cb),
    .spa_base_i(ab), .spp_base_i(sb),
    .addr_valid_i(av), .addr_i(addr),
    .hit_valid_o(hv), .hit_o(hit)
  );

  function automatic logic [31:0] step(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Independent restatement of R5..R9
  function automatic int ew(int m, int t);
    int sp;
    sp = (m >= 2 && m <= 4) ? 1 : ((m >= 5 && m <= 9) ? 2 : 0);
    if (m > 9) return 0;
    if (t == 0) return (m < 2) ? 12 : (m < 6) ? 10 : (m < 8) ? 15 : 16;
    if (t == 1) return (m < 4) ? 11 : (m < 6) ? 13 : 0;
    if (t == 2) return (m == 1) ? 9 : (m == 3) ? 6 : (m == 4 || m == 5) ? 13 : 0;
    if (t == 3) return (sp == 1) ? 7 : (sp == 2) ? 10 : 0;
    return (sp != 0) ? 11 : 0;
  endfunction

  function automatic logic [16:0] emask(int t);
    case (t)
      0: return {nb, 10'h3FF};
      1: return {pb, 11'h7FF};
      2: return {cb, 6'h3F};
      3: return {ab, 7'h7F};
      default: return {sb, 11'h7FF};
    endcase
  endfunction

  // R4 restated bit by bit
  function automatic bit emember(logic [16:0] a, logic [16:0] m, int w);
    if (w == 0) return 1'b0;
    for (int b = 0; b < AW; b++) begin
      if (b < w) begin
        if (a[b] && !m[b]) return 1'b0;
      end else if (a[b] != m[b]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int m, logic [6:0] n, logic [5:0] p, logic [10:0] c,
                         logic [9:0] a, logic [5:0] s);
    mode = 4'(m); nb = n; pb = p; cb = c; ab = a; sb = s;
    @(negedge clk);
  endtask

  // Drive at a falling edge, sample one falling edge later
  task automatic probe(logic [16:0] a);
    addr = a; av = 1'b1;
    @(negedge clk);
    av = 1'b0;
  endtask

  task automatic sweep_check(logic [16:0] a);
    string tag;
    probe(a);
    chk("R2 valid", int'(hv), 1);
    for (int t = 0; t < 5; t++) begin
      if (mode > 9) tag = "R9";
      else if (t == 0) tag = "R5";
      else if (t == 1) tag = "R6";
      else if (t == 2) tag = "R7";
      else tag = "R8";
      chk(tag, int'(hit[t]), int'(emember(a, emask(t), ew(int'(mode), t))));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] a;
    rst_n = 1'b0; av = 1'b0; addr = '0;
    mode = 4'd3; nb = 7'h24; pb = '1; cb = '1; ab = '1; sb = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(hv), 0);
    chk("R1 reset hit", int'(hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(hit), 0);

    // R3: mode code 3, name width 10, mask 093FF
    set_cfg(3, 7'h24, 6'h3F, 11'h7FF, 10'h3FF, 6'h3F);
    probe(17'h09157); chk("R3 name hit", int'(hit[0]), 1);
    probe(17'h09000); chk("R3 lowest", int'(hit[0]), 1);
    probe(17'h093FF); chk("R3 highest", int'(hit[0]), 1);
    probe(17'h09400); chk("R3 above", int'(hit[0]), 0);

    // R2: no strobe clears output
    @(negedge clk);
    chk("R2 idle valid", int'(hv), 0);
    chk("R2 idle hit", int'(hit), 0);

    // R4: mode code 6, name width 15, non-contiguous footprint
    set_cfg(6, 7'h24, 6'h3F, 11'h7FF, 10'h3FF, 6'h3F);
    probe(17'h08121); chk("R4 overlap hit", int'(hit[0]), 1);
    probe(17'h0A121); chk("R4 hole miss", int'(hit[0]), 0);
    probe(17'h0D521); chk("R4 sum miss", int'(hit[0]), 0);

    // R9: pattern table unused in code 6
    probe(17'h1FFFF); chk("R9 unused pattern", int'(hit[1]), 0);
    set_cfg(12, 7'h7F, 6'h3F, 11'h7FF, 10'h3FF, 6'h3F);
    probe(17'h1FFFF); chk("R9 reserved", int'(hit), 0);

    // R10: change and probe in the same cycle, then one cycle later
    set_cfg(3, 7'h24, 6'h3F, 11'h7FF, 10'h3FF, 6'h3F);
    nb = 7'h00;
    probe(17'h09157); chk("R10 old config", int'(hit[0]), 1);
    probe(17'h09157); chk("R10 new config", int'(hit[0]), 0);

    // Sweep all mode codes over several base patterns
    for (int bs = 0; bs < 4; bs++) begin
      for (int m = 0; m < 16; m++) begin
        rng = step(rng);
        case (bs)
          0: set_cfg(m, 7'h7F, 6'h3F, 11'h7FF, 10'h3FF, 6'h3F);
          1: set_cfg(m, 7'h24, 6'h05, 11'h2C5, 10'h1A3, 6'h2A);
          2: set_cfg(m, 7'h00, 6'h00, 11'h000, 10'h000, 6'h00);
          default: set_cfg(m, rng[6:0], rng[12:7], rng[23:13], rng[31:22], rng[5:0]);
        endcase
        for (int n = 0; n < 100; n++) begin
          int t;
          int w;
          rng = step(rng);
          t = n % 5;
          w = ew(m, t);
          a = emask(t) & (rng[16:0] | (17'h1FFFF << w));
          if (n % 4 == 3) a = a ^ (17'h1 << (rng[24:20] % 17));
          if (n % 10 == 0) a = rng[26:10];
          sweep_check(a);
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule